// File: doc/BRIEF.md
# UART Transmitter with Line Control

This block turns bytes written into its transmit buffer into asynchronous serial frames on one output line. A push-style write port stores characters. A full flag shows when the buffer cannot take another one, and a sticky overflow flag records any write that was dropped. The frame shape comes from a set of line-control inputs:

- buffered or single-character mode;
- one or two stop bits;
- parity off, odd, even, forced one or forced zero;
- a 9-bit mode that sends an address flag in the parity slot;
- a break request.

Bit timing comes from an external baud enable pulse. Each serial bit lasts a fixed number of those pulses.

Each character is sent as follows:

- A low start bit comes first.
- The data bits follow, least significant first.
- An optional parity-slot bit comes next.
- One or two high stop bits end the frame.

The frame options are captured at the moment a character leaves the buffer. A break request never cuts a character short. The line drops low only once the current frame has ended, and it stays low while the request is held. Characters still waiting in the buffer are kept and go out in order once the request is removed.

Top module: `uart_tx_lc`

## Requirements
- R1: After reset the line output is high, the full flag is 0 and the overflow flag is 0. Whenever no frame or break is in progress, the line is high.
- R2: A frame is one low start bit, then 8 data bits least significant bit first, then the stop bit(s) at high level. Each bit lasts 16 baud-enable pulses.
- R3: With fifo_en_i = 1 the buffer holds 16 characters, which are sent in write order. full_o rises when the 16th character is stored.
- R4: With fifo_en_i = 0 the buffer holds a single character. full_o is 1 as soon as one unsent character is stored, and a further write is not sent.
- R5: A write while full_o is 1 is dropped and sets overflow_o. overflow_o stays 1 until reset.
- R6: With two_stop_i = 1 each frame ends with two high stop bits. With two_stop_i = 0 it ends with one.
- R7: With nine_bit_i = 0, par_en_i = 1 and stick_i = 0, a parity bit follows the data. If even_sel_i = 0 it makes the count of ones in data plus parity odd. If even_sel_i = 1 it makes that count even.
- R8: With nine_bit_i = 0, par_en_i = 1 and stick_i = 1, the parity slot is forced. It is 1 when even_sel_i = 0 and 0 when even_sel_i = 1.
- R9: With nine_bit_i = 0 and par_en_i = 0, no parity bit is sent, so the stop bit follows the last data bit.
- R10: With nine_bit_i = 1, a parity slot is always sent and carries addr_flag_i. par_en_i, stick_i and even_sel_i have no effect.
- R11: When break_i is raised, a frame in progress completes unchanged. After that, the line is held low for as long as break_i stays 1.
- R12: While break is active, no character is taken from the buffer. After break_i is cleared, the buffered characters are sent in their original order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the transmit buffer |
| wr_data_i | input | 8 | Character to store |
| full_o | output | 1 | Buffer cannot accept a write |
| overflow_o | output | 1 | Sticky: a write was dropped |
| fifo_en_i | input | 1 | 1 = 16-entry buffer, 0 = single character |
| two_stop_i | input | 1 | 1 = two stop bits |
| par_en_i | input | 1 | Parity enable |
| even_sel_i | input | 1 | Even parity select / forced value select |
| stick_i | input | 1 | Forced parity |
| nine_bit_i | input | 1 | Send address flag in parity slot |
| addr_flag_i | input | 1 | Address flag value for 9-bit mode |
| break_i | input | 1 | Break request |
| baud_tick_i | input | 1 | Baud enable pulse, 16 per bit |
| tx_o | output | 1 | Serial output, idle high |

## Verification
Flag results are due one clock after the write edge. full_o and overflow_o are therefore sampled on the falling edge that follows the write, and the same applies to the drop of a write made while full.

Line results are due in the cycle after a character is popped, when the start bit begins. Every bit then lasts 16 pulses, which is 32 clocks at the bench's pulse rate. A monitor therefore detects the falling start edge and samples each later bit 16 clocks into its 32-clock window. The start-bit width is measured directly, and the measured width may vary by one pulse phase.

Break checks follow the same timing. The line is sampled only after the frame that was in progress has fully ended. The resumed characters are then expected one clock after break_i is cleared.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_BREAK
  } tx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              par_on;
    logic              par_bit;
    logic              two_stop;
  } frame_t;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  input  logic              single_i,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  // single-character mode caps the occupancy at one entry
  assign full_o  = single_i ? (cnt_q != '0) : (cnt_q == CNT_MAX);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_o    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      if (push_i && full_o) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_en_i,
  input  logic              even_sel_i,
  input  logic              stick_i,
  input  logic              nine_bit_i,
  input  logic              addr_flag_i,
  output logic              par_on_o,
  output logic              par_bit_o
);
  always_comb begin
    par_on_o  = par_en_i;
    par_bit_o = 1'b0;
    if (nine_bit_i) begin
      par_on_o  = 1'b1;
      par_bit_o = addr_flag_i;
    end else if (stick_i) begin
      par_bit_o = !even_sel_i;
    end else begin
      par_bit_o = even_sel_i ? (^data_i) : !(^data_i);
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   brk_i,
  input  logic   avail_i,
  input  frame_t frame_i,
  output logic   pop_o,
  output logic   tx_o,
  output logic   busy_o,
  output logic   brk_o
);
  localparam int unsigned TCW   = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [TCW-1:0]   TICK_LAST = TCW'(TICKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

  tx_state_e        state_q;
  frame_t           frame_q;
  logic [TCW-1:0]   tick_cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             bit_done;

  assign bit_done = tick_i && (tick_cnt_q == TICK_LAST);
  // break has priority over a waiting character at the frame boundary
  assign pop_o    = (state_q == ST_IDLE) && !brk_i && avail_i;
  assign busy_o   = (state_q != ST_IDLE) && (state_q != ST_BREAK);
  assign brk_o    = (state_q == ST_BREAK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      frame_q    <= '0;
      tick_cnt_q <= '0;
      idx_q      <= '0;
    end else begin
      if (busy_o && tick_i) tick_cnt_q <= bit_done ? '0 : tick_cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          tick_cnt_q <= '0;
          idx_q      <= '0;
          if (brk_i) state_q <= ST_BREAK;
          else if (avail_i) begin
            frame_q <= frame_i;
            state_q <= ST_START;
          end
        end
        ST_BREAK: if (!brk_i) state_q <= ST_IDLE;
        ST_START: if (bit_done) state_q <= ST_DATA;
        ST_DATA: begin
          if (bit_done) begin
            if (idx_q == IDX_LAST) state_q <= frame_q.par_on ? ST_PAR : ST_STOP1;
            else idx_q <= idx_q + 1'b1;
          end
        end
        ST_PAR:   if (bit_done) state_q <= ST_STOP1;
        ST_STOP1: if (bit_done) state_q <= frame_q.two_stop ? ST_STOP2 : ST_IDLE;
        ST_STOP2: if (bit_done) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START, ST_BREAK: tx_o = 1'b0;
      ST_DATA:            tx_o = frame_q.data[idx_q];
      ST_PAR:             tx_o = frame_q.par_bit;
      default:            tx_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_tx_lc.sv
module uart_tx_lc
  import uart_tx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH    = 16,
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  output logic              overflow_o,
  input  logic              fifo_en_i,
  input  logic              two_stop_i,
  input  logic              par_en_i,
  input  logic              even_sel_i,
  input  logic              stick_i,
  input  logic              nine_bit_i,
  input  logic              addr_flag_i,
  input  logic              break_i,
  input  logic              baud_tick_i,
  output logic              tx_o
);
  logic [DATA_W-1:0] fifo_q;
  logic              fifo_empty, fifo_pop;
  logic              par_on, par_bit;
  logic              line_busy, brk_active;
  frame_t            next_frame;

  uart_tx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (wr_en_i),
    .data_i   (wr_data_i),
    .pop_i    (fifo_pop),
    .single_i (!fifo_en_i),
    .data_o   (fifo_q),
    .empty_o  (fifo_empty),
    .full_o   (full_o),
    .ovf_o    (overflow_o)
  );

  uart_tx_parity #(.DATA_W(DATA_W)) u_parity (
    .data_i      (fifo_q),
    .par_en_i    (par_en_i),
    .even_sel_i  (even_sel_i),
    .stick_i     (stick_i),
    .nine_bit_i  (nine_bit_i),
    .addr_flag_i (addr_flag_i),
    .par_on_o    (par_on),
    .par_bit_o   (par_bit)
  );

  // frame options are captured when the character leaves the buffer
  assign next_frame = '{data: fifo_q, par_on: par_on, par_bit: par_bit, two_stop: two_stop_i};

  uart_tx_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (baud_tick_i),
    .brk_i   (break_i),
    .avail_i (!fifo_empty),
    .frame_i (next_frame),
    .pop_o   (fifo_pop),
    .tx_o    (tx_o),
    .busy_o  (line_busy),
    .brk_o   (brk_active)
  );
endmodule

// File: rtl/uart_tx_lc_chk.sv
module uart_tx_lc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic full_o,
  input logic overflow_o,
  input logic fifo_en_i,
  input logic break_i,
  input logic tx_o,
  input logic pop,
  input logic brk_active,
  input logic busy
);
  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !brk_active) |-> tx_o);

  assert_char_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && wr_en_i && !full_o && !pop) |=> (full_o || fifo_en_i));

  assert_ovf_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> overflow_o);

  assert_ovf_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  assert_break_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_active |-> !tx_o);

  assert_break_after_frame_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_active) |-> ($past(!busy) && $past(break_i)));

  assert_no_pop_in_break_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_active || break_i) |-> !pop);
endmodule

bind uart_tx_lc uart_tx_lc_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .full_o     (full_o),
  .overflow_o (overflow_o),
  .fifo_en_i  (fifo_en_i),
  .break_i    (break_i),
  .tx_o       (tx_o),
  .pop        (fifo_pop),
  .brk_active (brk_active),
  .busy       (line_busy)
);

// File: tb/tb_uart_tx_lc.sv
`timescale 1ns/1ps
module tb_uart_tx_lc;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       full_o, overflow_o, tx_o;
  logic       fifo_en_i = 1'b1, two_stop_i = 1'b0, par_en_i = 1'b0, even_sel_i = 1'b0;
  logic       stick_i = 1'b0, nine_bit_i = 1'b0, addr_flag_i = 1'b0, break_i = 1'b0;
  logic       baud_tick_i = 1'b0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] d;
    bit         has_par;
    bit         par;
    bit         two;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk_i = ~clk_i;

  // one baud enable every other clock: 16 pulses = 32 clocks per bit
  initial forever begin
    @(negedge clk_i);
    baud_tick_i = ~baud_tick_i;
  end

  uart_tx_lc dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .full_o(full_o), .overflow_o(overflow_o), .fifo_en_i(fifo_en_i),
    .two_stop_i(two_stop_i), .par_en_i(par_en_i), .even_sel_i(even_sel_i),
    .stick_i(stick_i), .nine_bit_i(nine_bit_i), .addr_flag_i(addr_flag_i),
    .break_i(break_i), .baud_tick_i(baud_tick_i), .tx_o(tx_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t expect_of(input logic [7:0] d, input string tag);
    exp_t e;
    e.d = d; e.two = two_stop_i; e.tag = tag;
    if (nine_bit_i) begin
      e.has_par = 1; e.par = addr_flag_i;
    end else if (!par_en_i) begin
      e.has_par = 0; e.par = 0;
    end else if (stick_i) begin
      e.has_par = 1; e.par = !even_sel_i;
    end else begin
      e.has_par = 1;
      e.par = even_sel_i ? (^d) : !(^d);
    end
    return e;
  endfunction

  task automatic wr_raw(input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input string tag);
    q.push_back(expect_of(d, tag));
    wr_raw(d);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk_i);
    repeat (420) @(negedge clk_i);
  endtask

  task automatic idle_ok(input string req);
    int lows = 0;
    repeat (400) begin
      @(negedge clk_i);
      if (!tx_o) lows++;
    end
    chk(lows == 0, req, "line not idle (extra frame)", lows, 0);
  endtask

  // monitor: decode frames, compare with the scoreboard queue
  initial forever begin
    exp_t e;
    logic [7:0] got;
    int cnt;
    while (q.size() == 0) @(negedge clk_i);
    while (tx_o !== 1'b1) @(negedge clk_i);
    while (tx_o !== 1'b0) @(negedge clk_i);
    e = q.pop_front();
    if (e.d[0]) begin
      cnt = 0;
      while (tx_o === 1'b0 && cnt < 40) begin
        cnt++;
        @(negedge clk_i);
      end
      chk(cnt >= 30 && cnt <= 33, "R2", "start bit width in clocks", cnt, 32);
      repeat (16) @(negedge clk_i);
      got[0] = tx_o;
    end else begin
      repeat (16) @(negedge clk_i);
      chk(tx_o == 1'b0, "R2", "start bit", tx_o, 0);
      repeat (32) @(negedge clk_i);
      got[0] = tx_o;
    end
    for (int i = 1; i < 8; i++) begin
      repeat (32) @(negedge clk_i);
      got[i] = tx_o;
    end
    chk(got == e.d, e.tag, "data byte", got, e.d);
    if (e.has_par) begin
      repeat (32) @(negedge clk_i);
      chk(tx_o == e.par, e.tag, "parity slot", tx_o, e.par);
    end
    repeat (32) @(negedge clk_i);
    chk(tx_o == 1'b1, e.has_par ? e.tag : "R9", "first stop bit", tx_o, 1);
    if (e.two) begin
      repeat (32) @(negedge clk_i);
      chk(tx_o == 1'b1, "R6", "second stop bit", tx_o, 1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk_i);
    chk(tx_o == 1'b1, "R1", "tx in reset", tx_o, 1);
    chk(full_o == 1'b0, "R1", "full in reset", full_o, 0);
    chk(overflow_o == 1'b0, "R1", "overflow in reset", overflow_o, 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(tx_o == 1'b1, "R1", "idle line", tx_o, 1);

    // R2 R3 R9: 8N1 buffered, back to back, order kept
    send(8'h55, "R2"); send(8'hA3, "R3"); send(8'h01, "R2"); send(8'hFF, "R9");
    drain();

    // R6 R7: odd parity, two stop bits
    two_stop_i = 1; par_en_i = 1; even_sel_i = 0;
    send(8'h07, "R7"); send(8'h30, "R7"); send(8'hC4, "R6");
    drain();
    // R7: even parity
    two_stop_i = 0; even_sel_i = 1;
    send(8'h07, "R7"); send(8'h96, "R7");
    drain();
    // R8: forced parity
    stick_i = 1; even_sel_i = 0;
    send(8'h03, "R8");
    drain();
    even_sel_i = 1;
    send(8'h01, "R8");
    drain();
    // R10: 9-bit mode, other parity controls ignored
    nine_bit_i = 1; par_en_i = 0; stick_i = 1; even_sel_i = 1; addr_flag_i = 1;
    send(8'h12, "R10");
    drain();
    addr_flag_i = 0; stick_i = 0; even_sel_i = 0; par_en_i = 1;
    send(8'h81, "R10");
    drain();
    nine_bit_i = 0; par_en_i = 0; stick_i = 0; even_sel_i = 0;

    // R11 R12: break mid frame, data behind it kept
    send(8'h5A, "R11");
    repeat (160) @(negedge clk_i);
    wr_raw(8'hC3); wr_raw(8'h3C);
    break_i = 1;
    repeat (420) @(negedge clk_i);
    chk(q.size() == 0, "R11", "frame before break not completed", q.size(), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (32) @(negedge clk_i);
      chk(tx_o == 1'b0, "R11", "line during break", tx_o, 0);
    end
    q.push_back(expect_of(8'hC3, "R12"));
    q.push_back(expect_of(8'h3C, "R12"));
    @(negedge clk_i);
    break_i = 0;
    drain();
    idle_ok("R12");

    // R3 R5: fill 16 while break holds the line
    break_i = 1;
    repeat (4) @(negedge clk_i);
    for (int i = 0; i < 15; i++) wr_raw(8'(8'h10 + i));
    chk(full_o == 1'b0, "R3", "full after 15", full_o, 0);
    wr_raw(8'h1F);
    chk(full_o == 1'b1, "R3", "full after 16", full_o, 1);
    chk(overflow_o == 1'b0, "R5", "overflow before drop", overflow_o, 0);
    wr_raw(8'hEE);
    chk(overflow_o == 1'b1, "R5", "overflow after drop", overflow_o, 1);
    for (int i = 0; i < 16; i++) q.push_back(expect_of(8'(8'h10 + i), "R3"));
    @(negedge clk_i);
    break_i = 0;
    drain();
    idle_ok("R5");

    // R4: single-character mode
    fifo_en_i = 0; break_i = 1;
    repeat (4) @(negedge clk_i);
    chk(full_o == 1'b0, "R4", "full when empty", full_o, 0);
    wr_raw(8'hA5);
    chk(full_o == 1'b1, "R4", "full after one", full_o, 1);
    wr_raw(8'h5A);
    chk(full_o == 1'b1, "R4", "full after dropped write", full_o, 1);
    q.push_back(expect_of(8'hA5, "R4"));
    @(negedge clk_i);
    break_i = 0;
    drain();
    idle_ok("R4");
    chk(overflow_o == 1'b1, "R5", "overflow sticky", overflow_o, 1);

    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    chk(overflow_o == 1'b0, "R5", "overflow cleared by reset", overflow_o, 0);
    chk(tx_o == 1'b1, "R1", "tx after second reset", tx_o, 1);
    rst_ni = 1;
    repeat (4) @(negedge clk_i);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule